// File: doc/BRIEF.md
# NAND Bus Latch and Page Register

This block is the device-side front end of a byte-wide NAND memory bus. Command, address and data share one 8-bit input port. The levels of the command-latch and address-latch enables at each rising edge of the active-low write strobe decide where that byte goes. A command byte goes to the command decoder. An address byte loads the column pointer. A data byte is stored in a 528-byte page register: 512 main bytes followed by 16 spare bytes. Each falling edge of the active-low read strobe puts the page byte at the column pointer on the output and advances the pointer.

All strobes are sampled on the block clock. Edges are found by comparing each strobe with its value one clock earlier. The bus has no back-pressure handshake. The host must watch the ready/busy line and may not strobe while it is asserted, because strobes that arrive then are dropped.

Program, erase and read-to-register operations are stood in for by a fixed-length busy timer, one length per operation. Ready/busy is open-drain: the block only drives a pull-low enable, and it keeps driving it whatever chip enable does. When write protect is low, program and erase cannot start, and a program or erase that is already running is cut short.

Top module: `nand_bus_frontend`

## Requirements
- R1: With `cle` high, the byte is taken as a command. The command codes are:
  - 0x80 sets up a program.
  - 0x10 starts the program.
  - 0x00 sets up a read.
  - 0x30 starts the read.
  - 0x60 sets up an erase.
  - 0xD0 starts the erase.

  A start code takes effect only directly after its own setup code. Otherwise it does nothing and busy stays low.
- R2: With `ale` high and `cle` low, the byte is taken as an address byte. The column pointer is loaded from the first two address bytes after a command: the first byte gives column bits 7:0 and bits 1:0 of the second give column bits 9:8. Any further address bytes are discarded. A column value of 528 or more loads 0.
- R3: With both `cle` and `ale` low, the byte is stored in the page register at the column pointer, and the pointer then advances by one.
- R4: A falling edge of `re_n` makes `io_out` show the page byte at the column pointer one clock after the edge is sampled, and the pointer then advances by one. The pointer wraps from 527 to 0.
- R5: `io_oe` is high only while `ce_n` and `re_n` are both low. While `ce_n` is high, write and read strobes have no effect.
- R6: Once a start command is accepted, `rb_pull_low` is high from the next clock for exactly T_READ, T_PROG or T_ERASE cycles, matching the operation.
- R7: While busy, write and read strobes are ignored and `ce_n` going high does not end the busy period.
- R8: While `wp_n` is low, the program and erase start commands are ignored. If `wp_n` is low during a program or erase busy period, busy ends at the next clock.
- R9: If a write-strobe rising edge and a read-strobe falling edge are sampled in the same clock, the write is performed, the read is dropped, `io_out` is unchanged and the pointer advances once.
- R10: After reset, `rb_pull_low` is low, `io_out` is 0x00 and `io_oe` follows only R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Active-low write strobe; bytes are latched on its rising edge |
| re_n | input | 1 | Active-low read strobe; a byte is presented on its falling edge |
| wp_n | input | 1 | Active-low write protect |
| io_in | input | 8 | Command, address or data byte |
| io_out | output | 8 | Page byte read out |
| io_oe | output | 1 | Output enable for the I/O pad; low means high impedance |
| rb_pull_low | output | 1 | Pull-low enable of the open-drain ready/busy line |

## Verification
The main same-cycle conflict is a write-strobe rising edge and a read-strobe falling edge landing on one clock. The bench provokes it by releasing `we_n` and lowering `re_n` at the same instant. It judges the result in two ways: `io_out` must still hold the byte of the previous read, and a later read-back must find the written byte at the old column. Two further overlaps are checked through busy timing:
- a data write attempted inside a program busy period must be dropped, and the column of the next write after busy exposes whether it was;
- `wp_n` falling inside an erase busy period must release busy on the very next clock.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_READ,
    MODE_PROG,
    MODE_ERASE
  } fe_mode_e;

  localparam logic [7:0] OP_READ_SETUP  = 8'h00;
  localparam logic [7:0] OP_READ_GO     = 8'h30;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_GO     = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
endpackage

// File: rtl/nand_strobe_decode.sv
module nand_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  input  logic busy,
  output logic cmd_stb,
  output logic addr_stb,
  output logic data_stb,
  output logic rd_stb
);
  logic we_q, re_q;
  logic we_rise, re_fall, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_rise  = we_n & ~we_q;
  assign re_fall  = ~re_n & re_q;
  assign live     = ~ce_n & ~busy;
  assign cmd_stb  = live & we_rise & cle;
  assign addr_stb = live & we_rise & ~cle & ale;
  assign data_stb = live & we_rise & ~cle & ~ale;
  assign rd_stb   = live & re_fall & ~we_rise;
endmodule

// File: rtl/nand_page_reg.sv
module nand_page_reg #(
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             rd,
  output logic [7:0]       rdata,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic [7:0]       mem [PAGE_BYTES];
  logic [COL_W-1:0] col_nxt;

  assign col_nxt = (col == LAST_COL) ? '0 : col + 1'b1;

  always_ff @(posedge clk) begin
    if (wr) mem[col] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      col   <= '0;
    end else begin
      if (rd) rdata <= mem[col];
      if (load) col <= load_col;
      else if (wr || rd) col <= col_nxt;
    end
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             abort,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (abort) cnt <= '0;
    else if (start) cnt <= len;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int T_READ     = 10,
  parameter int T_PROG     = 30,
  parameter int T_ERASE    = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_pull_low
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int T_MAX0 = (T_READ > T_PROG) ? T_READ : T_PROG;
  localparam int T_MAX  = (T_MAX0 > T_ERASE) ? T_MAX0 : T_ERASE;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic cmd_stb, addr_stb, data_stb, rd_stb, busy;
  logic go_read, go_prog, go_erase, start, abort, hv_op;
  logic [CNT_W-1:0] len;
  fe_mode_e mode;
  logic [1:0] addr_idx;
  logic [7:0] col_lo;
  logic [COL_W-1:0] addr_raw, load_col, col;
  logic col_load;

  nand_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .busy(busy),
    .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb), .rd_stb(rd_stb)
  );

  assign go_read  = cmd_stb && (io_in == OP_READ_GO)  && (mode == MODE_READ);
  assign go_prog  = cmd_stb && (io_in == OP_PROG_GO)  && (mode == MODE_PROG)  && wp_n;
  assign go_erase = cmd_stb && (io_in == OP_ERASE_GO) && (mode == MODE_ERASE) && wp_n;
  assign start    = go_read | go_prog | go_erase;
  assign abort    = busy && hv_op && !wp_n;

  always_comb begin
    if (go_erase)     len = CNT_W'(T_ERASE);
    else if (go_prog) len = CNT_W'(T_PROG);
    else              len = CNT_W'(T_READ);
  end

  nand_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .abort(abort), .busy(busy)
  );

  always_comb begin
    addr_raw = '0;
    if (addr_idx == 2'd0) begin
      addr_raw[7:0] = io_in;
    end else begin
      addr_raw[7:0]       = col_lo;
      addr_raw[COL_W-1:8] = io_in[COL_W-9:0];
    end
    load_col = (int'(addr_raw) >= PAGE_BYTES) ? '0 : addr_raw;
  end

  assign col_load = addr_stb && (addr_idx != 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_IDLE;
      hv_op    <= 1'b0;
      addr_idx <= '0;
      col_lo   <= '0;
    end else begin
      if (cmd_stb) begin
        addr_idx <= '0;
        case (io_in)
          OP_READ_SETUP:  mode <= MODE_READ;
          OP_PROG_SETUP:  mode <= MODE_PROG;
          OP_ERASE_SETUP: mode <= MODE_ERASE;
          default:        mode <= MODE_IDLE;
        endcase
      end
      if (start) hv_op <= go_prog | go_erase;
      if (addr_stb && addr_idx != 2'd2) begin
        addr_idx <= addr_idx + 1'b1;
        if (addr_idx == 2'd0) col_lo <= io_in;
      end
    end
  end

  nand_page_reg #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(col_load), .load_col(load_col),
    .wr(data_stb), .wdata(io_in), .rd(rd_stb), .rdata(io_out), .col(col)
  );

  assign io_oe       = ~ce_n & ~re_n;
  assign rb_pull_low = busy;
endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker #(
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp_n,
  input logic             busy,
  input logic             hv_op,
  input logic             cmd_stb,
  input logic             rd_stb,
  input logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) < PAGE_BYTES); // R2

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stb)); // R6

  AST_BUSY_FREEZE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(col)); // R7

  AST_WP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hv_op && !wp_n) |=> !busy); // R8

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (col == (($past(col) == LAST_COL) ? '0 : $past(col) + 1'b1))); // R4
endmodule

bind nand_bus_frontend nand_fe_checker #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .busy(busy), .hv_op(hv_op),
  .cmd_stb(cmd_stb), .rd_stb(rd_stb), .col(col)
);

// File: tb/tb_nand_bus_frontend.sv
`timescale 1ns/1ps
module tb_nand_bus_frontend;
  localparam int PB = 528;
  localparam int TR = 5;
  localparam int TP = 8;
  localparam int TE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb_pull_low;

  always #5 clk = ~clk;

  nand_bus_frontend #(.PAGE_BYTES(PB), .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rb_pull_low(rb_pull_low)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] model [PB];
  int col_m = 0;
  logic [7:0] exp_q [$];
  event rd_ev;
  string rd_tag = "R4";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d); endtask

  task automatic data(input logic [7:0] d);
    wr(1'b0, 1'b0, d);
    model[col_m] = d;
    col_m = (col_m + 1) % PB;
  endtask

  task automatic set_addr(input int c);
    wr(1'b0, 1'b1, c[7:0]);
    wr(1'b0, 1'b1, {6'b0, c[9:8]});
    wr(1'b0, 1'b1, 8'hA5);
    wr(1'b0, 1'b1, 8'h5A);
    col_m = (c >= PB) ? 0 : c;
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[col_m]);
      col_m = (col_m + 1) % PB;
      @(negedge clk); ce_n = 1'b0; re_n = 1'b0;
      @(negedge clk); -> rd_ev;
      @(negedge clk); re_n = 1'b1;
    end
  endtask

  task automatic wait_busy(input int exp, input string req);
    int n = 0;
    while (rb_pull_low && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
  endtask

  always begin
    @(rd_ev);
    if (exp_q.size() == 0) chk(1'b0, rd_tag, io_out, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(io_out == e, rd_tag, io_out, e);
      chk(io_oe == 1'b1, "R5", io_oe, 1);
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rb_pull_low == 1'b0, "R10", rb_pull_low, 0);
    chk(io_out == 8'h00, "R10", io_out, 0);
    chk(io_oe == 1'b0, "R10", io_oe, 0);

    // R1: start code without setup is ignored
    cmd(8'h10);
    chk(rb_pull_low == 1'b0, "R1", rb_pull_low, 0);

    // R3, R6: program ten bytes
    cmd(8'h80); set_addr(0);
    for (int i = 0; i < 10; i++) data(8'h30 + 8'(i));
    cmd(8'h10);
    wait_busy(TP, "R6");

    // R7: write during busy is dropped
    cmd(8'h80); set_addr(10); data(8'h5A);
    cmd(8'h10);
    wr(1'b0, 1'b0, 8'hEE);
    wait_busy(TP - 3, "R7");
    data(8'h6B);

    // R7: ce_n high does not end erase busy
    cmd(8'h60); set_addr(0); cmd(8'hD0);
    ce_n = 1'b1;
    wait_busy(TE, "R7");
    ce_n = 1'b0;

    // R1, R4: read back
    cmd(8'h00); set_addr(0); cmd(8'h30);
    wait_busy(TR, "R6");
    rd_tag = "R4";
    read_n(6);

    // R5: read strobe with ce_n high
    @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
    @(negedge clk);
    chk(io_oe == 1'b0, "R5", io_oe, 0);
    @(negedge clk);
    chk(io_oe == 1'b0, "R5", io_oe, 0);
    re_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    rd_tag = "R5";
    read_n(6);

    // R9: write rise and read fall in one clock
    @(negedge clk); ce_n = 1'b0; cle = 1'b0; ale = 1'b0; io_in = 8'hC3; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; re_n = 1'b0;
    @(negedge clk);
    chk(io_out == 8'h6B, "R9", io_out, 8'h6B);
    re_n = 1'b1;
    model[12] = 8'hC3;
    cmd(8'h00); set_addr(12); cmd(8'h30);
    wait_busy(TR, "R6");
    rd_tag = "R9";
    read_n(1);

    // R4: column wrap through the spare bytes
    cmd(8'h80); set_addr(526);
    data(8'hA1); data(8'hA2); data(8'hA3);
    cmd(8'h10);
    wait_busy(TP, "R6");
    cmd(8'h00); set_addr(526); cmd(8'h30);
    wait_busy(TR, "R6");
    rd_tag = "R4";
    read_n(3);

    // R2: out-of-range column loads 0
    cmd(8'h00); set_addr(600); cmd(8'h30);
    wait_busy(TR, "R6");
    rd_tag = "R2";
    read_n(1);

    // R8: write protect blocks program start
    wp_n = 1'b0;
    cmd(8'h80); set_addr(100); data(8'h77);
    cmd(8'h10);
    chk(rb_pull_low == 1'b0, "R8", rb_pull_low, 0);
    wp_n = 1'b1;

    // R8: write protect cuts erase busy short
    cmd(8'h60); set_addr(0); cmd(8'hD0);
    @(negedge clk); @(negedge clk);
    chk(rb_pull_low == 1'b1, "R8", rb_pull_low, 1);
    wp_n = 1'b0;
    @(negedge clk);
    chk(rb_pull_low == 1'b0, "R8", rb_pull_low, 0);
    wp_n = 1'b1;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule